// File: doc/BRIEF.md
# Forward-Difference Polynomial Address Generator

This block walks a target raster and, for every target pixel, presents the matching source-image coordinate. The coordinate is a polynomial in the target position. It is evaluated by forward differencing, so the datapath needs only wide adders and no multipliers. A host first writes a set of 48-bit coefficients: the start value, the difference terms along a line, the difference terms between lines, and the difference term between pages. It then issues a start strobe. After that a walk controller drives three step strobes: next pixel, next line and next page.

Each accepted strobe yields a new coordinate in the next cycle, and a valid flag is raised alongside it. A step can be accepted on every clock, so the block keeps up with one address per cycle. The 48-bit accumulator value is read as a fixed-point number with 24 integer bits and 24 fraction bits. The integer part goes out as the source address. A run-time selectable number of the most significant fraction bits, from 8 to 16, goes out for a downstream interpolator.

Top module: `fdp_addr_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, src_vld is 0, src_addr is 0 and src_frac is 0.
- R2: A start strobe loads the working value from coefficient slot 0. In the next cycle src_addr shows bits 47:24 of that coefficient, and src_frac shows the top bits of bits 23:0.
- R3: A pixel step adds the current first-order pixel term to the value, using its value from before the step. In the same step it adds coefficient slot 2 to that term. After a start and n pixel steps, the value is X0 + n*C1 + n(n-1)/2*C2, where X0, C1 and C2 are slots 0, 1 and 2.
- R4: A line step does four things. It adds the line term to the line-start value. It adds slot 4 to the line term. It adds slot 5 to the line-start pixel term. It then reloads the value and the first-order pixel term from these updated line-start values. After a start, line k begins at X0 + k*V1 + k(k-1)/2*V2, where V1 and V2 are slots 3 and 4, and its pixel term is C1 + k*slot5.
- R5: A page step adds coefficient slot 6 to the page-start value. It then loads that sum into the line-start value and the working value. It restores the line term from slot 3 and both pixel first-order terms from slot 1.
- R6: When several strobes arrive in the same cycle, exactly one is applied, by priority start > page > line > pixel.
- R7: src_vld is 1 in the cycle after any cycle with an accepted strobe and 0 otherwise. With a strobe held high, a new address is presented every cycle. With no strobe, src_addr and src_frac hold their values.
- R8: src_frac carries the top F bits of the accumulator's fraction field (bits 23:0), right-aligned, with the upper bits zero. F is frac_bits clamped to the range 8..16, so values below 8 act as 8 and values above 16 act as 16.
- R9: A write with wr_idx 0..6 sets that coefficient slot. A write to index 7 has no effect. Coefficient registers have no reset value.
- R10: All accumulation is modulo 2^48, so a value that passes 2^48 - 1 wraps to the low end of the address range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the working state |
| wr_en | input | 1 | Coefficient write enable |
| wr_idx | input | 3 | Coefficient slot (0 start value, 1 pixel first-order, 2 pixel second-order, 3 line first-order, 4 line second-order, 5 line increment of pixel term, 6 page first-order) |
| wr_data | input | 48 | Coefficient value, two's complement, 24.24 fixed point |
| step_start | input | 1 | Begin a transform at the first target position |
| step_page | input | 1 | Advance to the next page |
| step_line | input | 1 | Advance to the next line |
| step_px | input | 1 | Advance to the next pixel in the line |
| frac_bits | input | 5 | Requested number of fraction output bits |
| src_addr | output | 24 | Integer source address |
| src_frac | output | 16 | Selected fraction bits, right-aligned |
| src_vld | output | 1 | New address presented this cycle |

## Verification
A held pixel strobe after a start tests the value against the closed-form quadratic. This shows whether the second-order term feeds the first-order one and whether the pre-step first-order value is used. Line sequences interleaved with pixel steps show whether both second-order line terms and the mixed increment are accumulated and reloaded. A page step placed after several lines must restore every line-level term. Simultaneous strobes expose the priority order. Sweeping frac_bits, including out-of-range values, tests the clamp and the bit placement. A start value close to 2^48 tests the modular wrap, and a write to the unused slot tests that it is ignored.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

  localparam int NUM_COEF = 7;

  typedef enum logic [2:0] {
    CI_X0  = 3'd0,
    CI_DU1 = 3'd1,
    CI_DU2 = 3'd2,
    CI_DV1 = 3'd3,
    CI_DV2 = 3'd4,
    CI_DUV = 3'd5,
    CI_DW1 = 3'd6
  } coef_idx_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_START,
    EV_PAGE,
    EV_LINE,
    EV_PIX
  } walk_ev_e;

  // Priority: start > page > line > pixel
  function automatic walk_ev_e pick_event(input logic s, input logic p,
                                          input logic l, input logic x);
    if (s)      return EV_START;
    else if (p) return EV_PAGE;
    else if (l) return EV_LINE;
    else if (x) return EV_PIX;
    else        return EV_NONE;
  endfunction

  function automatic int clamp_frac(input int req, input int lo, input int hi);
    if (req < lo)      return lo;
    else if (req > hi) return hi;
    else               return req;
  endfunction

endpackage

// File: rtl/fdp_coef_bank.sv
module fdp_coef_bank #(
  parameter int ACC_W = 48,
  parameter int NCOEF = fdp_pkg::NUM_COEF,
  parameter int IDX_W = 3
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [ACC_W-1:0]             wr_data,
  output logic [NCOEF-1:0][ACC_W-1:0]  coef
);

  // No reset: the host must program every slot before use.
  for (genvar g = 0; g < NCOEF; g++) begin : g_slot
    logic [ACC_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_idx) == g)) q <= wr_data;
    end
    assign coef[g] = q;
  end

endmodule

// File: rtl/fdp_walk_core.sv
module fdp_walk_core
  import fdp_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int NCOEF = fdp_pkg::NUM_COEF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  walk_ev_e                    ev,
  input  logic [NCOEF-1:0][ACC_W-1:0] coef,
  output logic [ACC_W-1:0]            acc_x
);

  logic [ACC_W-1:0] c_x0, c_du1, c_du2, c_dv1, c_dv2, c_duv, c_dw1;
  assign c_x0  = coef[CI_X0];
  assign c_du1 = coef[CI_DU1];
  assign c_du2 = coef[CI_DU2];
  assign c_dv1 = coef[CI_DV1];
  assign c_dv2 = coef[CI_DV2];
  assign c_duv = coef[CI_DUV];
  assign c_dw1 = coef[CI_DW1];

  // Working accumulators: pixel level, line-start level, page-start level
  logic [ACC_W-1:0] x, du1;
  logic [ACC_W-1:0] lx, dv1, ldu1;
  logic [ACC_W-1:0] px;

  logic [ACC_W-1:0] px_nxt, lx_nxt, ldu1_nxt;
  assign px_nxt   = px + c_dw1;
  assign lx_nxt   = lx + dv1;
  assign ldu1_nxt = ldu1 + c_duv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x    <= '0;
      du1  <= '0;
      lx   <= '0;
      dv1  <= '0;
      ldu1 <= '0;
      px   <= '0;
    end else begin
      unique case (ev)
        EV_START: begin
          x <= c_x0;  lx <= c_x0;  px <= c_x0;
          du1 <= c_du1;  ldu1 <= c_du1;  dv1 <= c_dv1;
        end
        EV_PAGE: begin
          px <= px_nxt;  lx <= px_nxt;  x <= px_nxt;
          dv1 <= c_dv1;  du1 <= c_du1;  ldu1 <= c_du1;
        end
        EV_LINE: begin
          lx   <= lx_nxt;    x   <= lx_nxt;
          dv1  <= dv1 + c_dv2;
          ldu1 <= ldu1_nxt;  du1 <= ldu1_nxt;
        end
        EV_PIX: begin
          x   <= x + du1;
          du1 <= du1 + c_du2;
        end
        default: ;
      endcase
    end
  end

  assign acc_x = x;

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_START) |=> (x == $past(c_x0)) && (du1 == $past(c_du1)));

  assert_pixel_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_PIX) |=> (x == $past(x) + $past(du1)));

  assert_line_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_LINE) |=> (x == lx) && (du1 == ldu1));

  assert_page_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_PAGE) |=> (x == px) && (lx == px) && (dv1 == $past(c_dv1)));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_NONE) |=> $stable(x));

endmodule

// File: rtl/fdp_out_fmt.sv
module fdp_out_fmt #(
  parameter int ACC_W    = 48,
  parameter int ADDR_W   = 24,
  parameter int FRAC_MIN = 8,
  parameter int FRAC_MAX = 16,
  parameter int SEL_W    = 5
) (
  input  logic [ACC_W-1:0]    acc,
  input  logic [SEL_W-1:0]    frac_bits,
  output logic [ADDR_W-1:0]   addr,
  output logic [FRAC_MAX-1:0] frac
);

  localparam int ACC_FRAC = ACC_W - ADDR_W;
  localparam int NOPT     = FRAC_MAX - FRAC_MIN + 1;

  assign addr = acc[ACC_W-1 -: ADDR_W];

  // One candidate per legal fraction width
  logic [FRAC_MAX-1:0] cand [NOPT];
  for (genvar g = 0; g < NOPT; g++) begin : g_opt
    logic [FRAC_MIN+g-1:0] top_bits;
    assign top_bits = acc[ACC_FRAC-1 -: (FRAC_MIN + g)];
    assign cand[g]  = FRAC_MAX'(top_bits);
  end

  int eff_bits;
  assign eff_bits = fdp_pkg::clamp_frac(int'(frac_bits), FRAC_MIN, FRAC_MAX);

  always_comb begin
    frac = '0;
    for (int k = 0; k < NOPT; k++) begin
      if (eff_bits == FRAC_MIN + k) frac = cand[k];
    end
  end

  logic unused_low;
  assign unused_low = ^acc[ACC_FRAC-FRAC_MAX-1:0];

endmodule

// File: rtl/fdp_addr_gen.sv
module fdp_addr_gen
  import fdp_pkg::*;
#(
  parameter int ACC_W    = 48,
  parameter int ADDR_W   = 24,
  parameter int FRAC_MIN = 8,
  parameter int FRAC_MAX = 16,
  parameter int SEL_W    = 5,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [ACC_W-1:0]    wr_data,
  input  logic                step_start,
  input  logic                step_page,
  input  logic                step_line,
  input  logic                step_px,
  input  logic [SEL_W-1:0]    frac_bits,
  output logic [ADDR_W-1:0]   src_addr,
  output logic [FRAC_MAX-1:0] src_frac,
  output logic                src_vld
);

  localparam int NCOEF = NUM_COEF;

  logic [NCOEF-1:0][ACC_W-1:0] coef;
  logic [ACC_W-1:0]            acc_x;
  walk_ev_e                    ev;
  logic                        any_step;

  assign ev       = pick_event(step_start, step_page, step_line, step_px);
  assign any_step = (ev != EV_NONE);

  fdp_coef_bank #(.ACC_W(ACC_W), .NCOEF(NCOEF), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .coef(coef)
  );

  fdp_walk_core #(.ACC_W(ACC_W), .NCOEF(NCOEF)) u_core (
    .clk(clk), .rst_n(rst_n), .ev(ev), .coef(coef), .acc_x(acc_x)
  );

  fdp_out_fmt #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .FRAC_MIN(FRAC_MIN),
                .FRAC_MAX(FRAC_MAX), .SEL_W(SEL_W)) u_fmt (
    .acc(acc_x), .frac_bits(frac_bits), .addr(src_addr), .frac(src_frac)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) src_vld <= 1'b0;
    else        src_vld <= any_step;
  end

  assert_vld_after_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_start || step_page || step_line || step_px) |=> src_vld);

  assert_vld_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_start || step_page || step_line || step_px) |=> !src_vld);

  assert_frac_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(frac_bits) >= FRAC_MIN) && (int'(frac_bits) <= FRAC_MAX))
      |-> ((src_frac >> frac_bits) == '0));

  assert_start_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_start |-> (ev == EV_START));

endmodule

// File: tb/fdp_addr_gen_bench.sv
`timescale 1ns/1ps
module fdp_addr_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [47:0] wr_data = '0;
  logic        step_start = 0, step_page = 0, step_line = 0, step_px = 0;
  logic [4:0]  frac_bits = 5'd16;
  logic [23:0] src_addr;
  logic [15:0] src_frac;
  logic        src_vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fdp_addr_gen u_fdp_addr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .step_start(step_start), .step_page(step_page), .step_line(step_line),
    .step_px(step_px), .frac_bits(frac_bits),
    .src_addr(src_addr), .src_frac(src_frac), .src_vld(src_vld)
  );

  localparam logic [47:0] X0  = 48'h000123_9ABCDE;
  localparam logic [47:0] DU1 = 48'h000002_100000;
  localparam logic [47:0] DU2 = 48'h000000_080000;
  localparam logic [47:0] DV1 = 48'h000010_000000;
  localparam logic [47:0] DV2 = 48'h000001_000000;
  localparam logic [47:0] DUV = 48'h000000_010000;
  localparam logic [47:0] DW1 = 48'h000100_000000;

  task automatic chk(input string req, input logic [47:0] v, input logic vld);
    checks++;
    if (src_addr !== v[47:24] || src_frac !== v[23:8] || src_vld !== vld) begin
      fails++;
      $display("FAIL %s: addr=%h frac=%h vld=%b expected addr=%h frac=%h vld=%b",
               req, src_addr, src_frac, src_vld, v[47:24], v[23:8], vld);
    end
  endtask

  task automatic chk_frac(input string req, input logic [15:0] exp_f);
    checks++;
    if (src_frac !== exp_f) begin
      fails++;
      $display("FAIL %s: frac=%h expected %h", req, src_frac, exp_f);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [47:0] d);
    @(negedge clk); wr_en = 1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic strobe(input logic s, input logic p, input logic l, input logic x);
    @(negedge clk);
    step_start = s; step_page = p; step_line = l; step_px = x;
    @(negedge clk);
    step_start = 0; step_page = 0; step_line = 0; step_px = 0;
  endtask

  task automatic load_all();
    wr(3'd0, X0);  wr(3'd1, DU1); wr(3'd2, DU2); wr(3'd3, DV1);
    wr(3'd4, DV2); wr(3'd5, DUV); wr(3'd6, DW1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 in reset", 48'h0, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", 48'h0, 1'b0);
  endtask

  task automatic t_start();
    load_all();
    wr(3'd7, 48'hFFFF_FFFF_FFFF);   // R9: unused slot, must be ignored
    strobe(1, 0, 0, 0);
    chk("R2 start value", X0, 1'b1);
  endtask

  task automatic t_pixel_run();
    logic [47:0] e;
    strobe(1, 0, 0, 0);
    @(negedge clk); step_px = 1;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      e = X0 + 48'(n) * DU1 + 48'(n * (n - 1) / 2) * DU2;
      if (n == 6) step_px = 0;
      chk("R3 quadratic pixel run / R7 per-cycle", e, 1'b1);
    end
    @(negedge clk);
    chk("R7 idle hold, vld low", X0 + 48'd6 * DU1 + 48'd15 * DU2, 1'b0);
  endtask

  task automatic t_lines();
    logic [47:0] l1, l2;
    strobe(1, 0, 0, 0);
    repeat (3) strobe(0, 0, 0, 1);
    strobe(0, 0, 1, 0);
    l1 = X0 + DV1;
    chk("R4 line 1 start", l1, 1'b1);
    strobe(0, 0, 0, 1);
    chk("R4 line 1 pixel term", l1 + DU1 + DUV, 1'b1);
    strobe(0, 0, 1, 0);
    l2 = X0 + 48'd2 * DV1 + DV2;
    chk("R4 line 2 start", l2, 1'b1);
    strobe(0, 0, 0, 1);
    strobe(0, 0, 0, 1);
    chk("R4 line 2 two pixels", l2 + 48'd2 * (DU1 + 48'd2 * DUV) + DU2, 1'b1);
  endtask

  task automatic t_page();
    logic [47:0] p1;
    strobe(1, 0, 0, 0);
    strobe(0, 0, 0, 1);
    strobe(0, 0, 1, 0);
    strobe(0, 0, 1, 0);
    strobe(0, 1, 0, 0);
    p1 = X0 + DW1;
    chk("R5 page start", p1, 1'b1);
    strobe(0, 0, 0, 1);
    chk("R5 pixel term restored", p1 + DU1, 1'b1);
    strobe(0, 0, 1, 0);
    strobe(0, 0, 0, 1);
    chk("R5 line terms restored", p1 + DV1 + DU1 + DUV, 1'b1);
  endtask

  task automatic t_priority();
    strobe(1, 0, 0, 0);
    strobe(0, 0, 0, 1);
    strobe(1, 1, 1, 1);
    chk("R6 start wins", X0, 1'b1);
    strobe(0, 0, 0, 1);
    strobe(0, 1, 1, 1);
    chk("R6 page over line and pixel", X0 + DW1, 1'b1);
    strobe(0, 0, 1, 1);
    chk("R6 line over pixel", X0 + DW1 + DV1, 1'b1);
  endtask

  task automatic t_frac();
    strobe(1, 0, 0, 0);
    frac_bits = 5'd8;  #1; chk_frac("R8 F=8",  16'h009A);
    frac_bits = 5'd12; #1; chk_frac("R8 F=12", 16'h09AB);
    frac_bits = 5'd16; #1; chk_frac("R8 F=16", 16'h9ABC);
    frac_bits = 5'd3;  #1; chk_frac("R8 clamp low", 16'h009A);
    frac_bits = 5'd20; #1; chk_frac("R8 clamp high", 16'h9ABC);
    frac_bits = 5'd16;
  endtask

  task automatic t_wrap();
    wr(3'd0, 48'hFFFFFF_F00000);
    wr(3'd1, 48'h000000_200000);
    strobe(1, 0, 0, 0);
    chk("R10 pre-wrap", 48'hFFFFFF_F00000, 1'b1);
    strobe(0, 0, 0, 1);
    chk("R10 wrap modulo 2^48", 48'h000000_100000, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_start();
    t_pixel_run();
    t_lines();
    t_page();
    t_priority();
    t_frac();
    t_wrap();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule